// File: doc/BRIEF.md
# Macro Engine ALU and Bitfield Datapath

This block computes the result value for every non-branch instruction of a small command-macro engine. Each instruction word selects an operation class in its low three bits. The classes are a register-register arithmetic/logic unit, an add of a signed immediate, and three bitfield forms. The bitfield forms cut a field out of one operand using a mask built from a size field, then either merge it into the other operand or shift it into place. In one bitfield form the shift amount comes from a register.

Arithmetic keeps a one-bit carry state that can chain across instructions. The caller stores the flag the block returns and presents it again with the next instruction. Subtraction uses the same flag as a "no borrow" indicator. The caller presents the decoded word, both operand values and the stored carry with `in_valid`. One clock later the block returns the result, the new carry and an error flag for unknown ALU codes. Register reads, writes and result dispatch belong to the surrounding engine.

Top module: `macro_exec_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, the next state has `out_valid`, `result`, `carry_out` and `bad_op` all zero.
- R2: An instruction accepted with `in_valid` at one edge appears on the outputs after that edge, with `out_valid` high. When `in_valid` is low at an edge, `out_valid` goes low and `result`, `carry_out` and `bad_op` keep their values.
- R3: Bits [2:0] select the class: 0 ALU, 1 add-immediate, 2 extract-insert, 3 extract-shift-left-immediate, 4 extract-shift-left-register. Class codes 5 to 7 give result 0 and `bad_op` 0, and `carry_out` equals `carry_in`.
- R4: The ALU code sits in bits [21:17]. Code 0 gives a+b. Code 1 gives a+b+`carry_in`. Both set `carry_out` to the carry out of bit 31.
- R5: ALU code 2 gives a−b. Code 3 gives a+~b+`carry_in`, so a carry of 0 subtracts one more. Both set `carry_out` to 1 exactly when no borrow occurs.
- R6: ALU codes 8 xor, 9 or, 10 and, 11 a AND NOT b and 12 nand give the bitwise result, and `carry_out` equals `carry_in`.
- R7: ALU codes 4 to 7 and 13 to 31 give result 0 with `bad_op` high, and `carry_out` equals `carry_in`. No other instruction raises `bad_op`.
- R8: Add-immediate gives src_a plus the sign extension of bits [31:14], and `carry_out` equals `carry_in`.
- R9: The bitfield mask is 2^size−1, with size in bits [26:22]. Size 0 selects an empty field, and size 31 selects the low 31 bits.
- R10: Extract-insert takes ((src_b >> s) & mask), with s in bits [21:17]. It places the field at position d, given by bits [31:27], replacing those bits of src_a. Field bits shifted past bit 31 are dropped.
- R11: Extract-shift-left-immediate gives ((src_b >> src_a[4:0]) & mask) << d.
- R12: Extract-shift-left-register gives ((src_b >> s) & mask) << src_a[4:0].
- R13: All bitfield classes and add-immediate leave `bad_op` low and pass `carry_in` to `carry_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands present this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | First operand value |
| src_b | input | 32 | Second operand value |
| carry_in | input | 1 | Stored carry / no-borrow flag |
| out_valid | output | 1 | Result registers updated by the last edge |
| result | output | 32 | Computed value |
| carry_out | output | 1 | Updated carry flag |
| bad_op | output | 1 | Unknown ALU code seen |

## Verification
The only state is the output register stage. A wrong value there shows at the ports one cycle after the instruction that loaded it. A fault in the hold path shows as a changed `result` or `carry_out` in a cycle where `in_valid` is low. Carry-chain mistakes stay hidden on wide-margin operands, so the vectors include values that ripple across all 32 bits. They also include subtract-with-borrow with both flag values. A mask or shift mistake shows only for particular size and position values, so the vectors cover size 0, size 31 and fields pushed past bit 31.

// File: rtl/mxd_pkg.sv
package mxd_pkg;

    localparam int DATA_W = 32;
    localparam int SH_W   = $clog2(DATA_W);
    localparam int FLD_W  = 5;
    localparam int IMM_W  = 18;

    typedef enum logic [2:0] {
        CLS_ALU     = 3'd0,
        CLS_ADDI    = 3'd1,
        CLS_BF_INS  = 3'd2,
        CLS_BF_SHLI = 3'd3,
        CLS_BF_SHLR = 3'd4
    } op_class_e;

    typedef enum logic [FLD_W-1:0] {
        ALU_ADD   = 5'd0,
        ALU_ADDC  = 5'd1,
        ALU_SUB   = 5'd2,
        ALU_SUBB  = 5'd3,
        ALU_XOR   = 5'd8,
        ALU_OR    = 5'd9,
        ALU_AND   = 5'd10,
        ALU_ANDN  = 5'd11,
        ALU_NAND  = 5'd12
    } alu_code_e;

    typedef struct packed {
        logic [2:0]       cls;
        logic [FLD_W-1:0] sub;     // ALU code, also bitfield source position
        logic [FLD_W-1:0] size;
        logic [FLD_W-1:0] dpos;
        logic [IMM_W-1:0] imm;
    } dec_t;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              carry;
        logic              bad;
    } res_t;

    function automatic dec_t split_word(input logic [31:0] w);
        dec_t d;
        d.cls  = w[2:0];
        d.sub  = w[21:17];
        d.size = w[26:22];
        d.dpos = w[31:27];
        d.imm  = w[31:14];
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] field_mask(input logic [FLD_W-1:0] sz);
        logic [DATA_W:0] one_hot;
        one_hot = {{DATA_W{1'b0}}, 1'b1} << sz;
        return one_hot[DATA_W-1:0] - {{(DATA_W-1){1'b0}}, 1'b1};
    endfunction

endpackage

// File: rtl/mxd_alu.sv
module mxd_alu
    import mxd_pkg::*;
(
    input  logic [FLD_W-1:0]  code,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              cin,
    output res_t              res
);
    logic [DATA_W-1:0] addend;
    logic              cy0;
    logic [DATA_W:0]   sum;
    logic              arith;

    always_comb begin
        arith  = 1'b1;
        addend = opb;
        cy0    = 1'b0;
        unique case (code)
            ALU_ADD:  begin addend = opb;  cy0 = 1'b0; end
            ALU_ADDC: begin addend = opb;  cy0 = cin;  end
            ALU_SUB:  begin addend = ~opb; cy0 = 1'b1; end
            ALU_SUBB: begin addend = ~opb; cy0 = cin;  end
            default:  arith = 1'b0;
        endcase
    end

    assign sum = {1'b0, opa} + {1'b0, addend} + {{DATA_W{1'b0}}, cy0};

    always_comb begin
        res.value = '0;
        res.carry = cin;
        res.bad   = 1'b0;
        if (arith) begin
            res.value = sum[DATA_W-1:0];
            res.carry = sum[DATA_W];
        end else begin
            unique case (code)
                ALU_XOR:  res.value = opa ^ opb;
                ALU_OR:   res.value = opa | opb;
                ALU_AND:  res.value = opa & opb;
                ALU_ANDN: res.value = opa & ~opb;
                ALU_NAND: res.value = ~(opa & opb);
                default:  res.bad   = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/mxd_bitfield.sv
module mxd_bitfield
    import mxd_pkg::*;
(
    input  logic [2:0]        cls,
    input  logic [FLD_W-1:0]  spos,
    input  logic [FLD_W-1:0]  size,
    input  logic [FLD_W-1:0]  dpos,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] value
);
    logic [DATA_W-1:0] mask;
    logic [SH_W-1:0]   src_sh;
    logic [SH_W-1:0]   dst_sh;
    logic [DATA_W-1:0] field;
    logic [DATA_W-1:0] placed;
    logic [DATA_W-1:0] hole;

    assign mask = field_mask(size);

    // Class 3 takes the source shift from the register; 2 and 4 from the word.
    assign src_sh = (cls == CLS_BF_SHLI) ? opa[SH_W-1:0] : spos[SH_W-1:0];
    assign dst_sh = (cls == CLS_BF_SHLR) ? opa[SH_W-1:0] : dpos[SH_W-1:0];

    assign field  = (opb >> src_sh) & mask;
    assign placed = field << dst_sh;
    assign hole   = ~(mask << dst_sh);

    always_comb begin
        if (cls == CLS_BF_INS) value = (opa & hole) | placed;
        else                   value = placed;
    end

    always_comb begin
        if (cls == CLS_BF_INS && size == '0)
            p_empty_insert_r9: assert (value == opa);
    end
endmodule

// File: rtl/macro_exec_datapath.sv
module macro_exec_datapath
    import mxd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] instr,
    input  logic [31:0] src_a,
    input  logic [31:0] src_b,
    input  logic        carry_in,
    output logic        out_valid,
    output logic [31:0] result,
    output logic        carry_out,
    output logic        bad_op
);
    dec_t              dec;
    res_t              alu_res;
    logic [DATA_W-1:0] bf_value;
    logic [DATA_W-1:0] imm_ext;
    res_t              nxt;

    assign dec = split_word(instr);

    mxd_alu u_alu (
        .code (dec.sub),
        .opa  (src_a),
        .opb  (src_b),
        .cin  (carry_in),
        .res  (alu_res)
    );

    mxd_bitfield u_bf (
        .cls   (dec.cls),
        .spos  (dec.sub),
        .size  (dec.size),
        .dpos  (dec.dpos),
        .opa   (src_a),
        .opb   (src_b),
        .value (bf_value)
    );

    assign imm_ext = {{(DATA_W-IMM_W){dec.imm[IMM_W-1]}}, dec.imm};

    always_comb begin
        nxt.value = '0;
        nxt.carry = carry_in;
        nxt.bad   = 1'b0;
        case (dec.cls)
            CLS_ALU:     nxt = alu_res;
            CLS_ADDI:    nxt.value = src_a + imm_ext;
            CLS_BF_INS,
            CLS_BF_SHLI,
            CLS_BF_SHLR: nxt.value = bf_value;
            default:     nxt.value = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            carry_out <= 1'b0;
            bad_op    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result    <= nxt.value;
                carry_out <= nxt.carry;
                bad_op    <= nxt.bad;
            end
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0 && !carry_out && !bad_op));

    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result) && $stable(carry_out) && $stable(bad_op)));

    p_bad_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && bad_op) |-> (result == '0));

    p_carry_pass_r13: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[2:0] != 3'd0) |=> (carry_out == $past(carry_in) && !bad_op));

    p_logic_carry_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[2:0] == 3'd0 && instr[21:17] >= 5'd8 && instr[21:17] <= 5'd12)
        |=> (carry_out == $past(carry_in) && !bad_op));
endmodule

// File: tb/macro_exec_datapath_bench.sv
module macro_exec_datapath_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] instr, src_a, src_b;
    logic        carry_in;
    logic        out_valid;
    logic [31:0] result;
    logic        carry_out, bad_op;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;  // 250 MHz

    macro_exec_datapath u_macro_exec_datapath (
        .clk, .rst, .in_valid, .instr, .src_a, .src_b, .carry_in,
        .out_valid, .result, .carry_out, .bad_op
    );

    function automatic logic [31:0] w_alu(input logic [4:0] code);
        return {10'd0, code, 14'd0, 3'd0};
    endfunction
    function automatic logic [31:0] w_imm(input logic [17:0] imm);
        return {imm, 11'd0, 3'd1};
    endfunction
    function automatic logic [31:0] w_bf(input logic [2:0] cls, input logic [4:0] sp,
                                         input logic [4:0] sz, input logic [4:0] dp);
        return {dp, sz, sp, 14'd0, cls};
    endfunction

    typedef struct packed {
        logic [31:0] w;
        logic [31:0] a;
        logic [31:0] b;
        logic        ci;
        logic [31:0] er;
        logic        ec;
        logic        eb;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{w_alu(0),  32'hFFFF_FFFF, 32'h1,         1'b0, 32'h0,         1'b1, 1'b0, 8'd4},  // R4 ripple
        '{w_alu(0),  32'h5,         32'h7,         1'b1, 32'hC,         1'b0, 1'b0, 8'd4},  // R4 cin ignored
        '{w_alu(1),  32'h5,         32'h7,         1'b1, 32'hD,         1'b0, 1'b0, 8'd4},  // R4
        '{w_alu(1),  32'hFFFF_FFFF, 32'h0,         1'b1, 32'h0,         1'b1, 1'b0, 8'd4},  // R4
        '{w_alu(2),  32'd10,        32'd3,         1'b0, 32'd7,         1'b1, 1'b0, 8'd5},  // R5
        '{w_alu(2),  32'd3,         32'd10,        1'b1, 32'hFFFF_FFF9, 1'b0, 1'b0, 8'd5},  // R5 borrow
        '{w_alu(3),  32'd10,        32'd3,         1'b0, 32'd6,         1'b1, 1'b0, 8'd5},  // R5
        '{w_alu(3),  32'd10,        32'd3,         1'b1, 32'd7,         1'b1, 1'b0, 8'd5},  // R5
        '{w_alu(3),  32'd0,         32'd0,         1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 8'd5},  // R5
        '{w_alu(8),  32'hF0F0_F0F0, 32'hFF00_FF00, 1'b1, 32'h0FF0_0FF0, 1'b1, 1'b0, 8'd6},  // R6
        '{w_alu(9),  32'hF0F0_F0F0, 32'hFF00_FF00, 1'b0, 32'hFFF0_FFF0, 1'b0, 1'b0, 8'd6},  // R6
        '{w_alu(10), 32'hF0F0_F0F0, 32'hFF00_FF00, 1'b1, 32'hF000_F000, 1'b1, 1'b0, 8'd6},  // R6
        '{w_alu(11), 32'hF0F0_F0F0, 32'hFF00_FF00, 1'b0, 32'h00F0_00F0, 1'b0, 1'b0, 8'd6},  // R6
        '{w_alu(12), 32'hF0F0_F0F0, 32'hFF00_FF00, 1'b1, 32'h0FFF_0FFF, 1'b1, 1'b0, 8'd6},  // R6
        '{w_alu(5),  32'h1,         32'h2,         1'b1, 32'h0,         1'b1, 1'b1, 8'd7},  // R7
        '{w_alu(13), 32'h1,         32'h2,         1'b0, 32'h0,         1'b0, 1'b1, 8'd7},  // R7
        '{w_imm(18'd5),     32'd100, 32'h0,        1'b1, 32'd105,       1'b1, 1'b0, 8'd8},  // R8
        '{w_imm(18'h3FFFF), 32'd100, 32'h0,        1'b0, 32'd99,        1'b0, 1'b0, 8'd8},  // R8
        '{w_imm(18'h20000), 32'd0,   32'h0,        1'b1, 32'hFFFE_0000, 1'b1, 1'b0, 8'd8},  // R8
        '{w_bf(3'd2, 5'd4, 5'd8, 5'd8),  32'hFFFF_FFFF, 32'h0000_0AB0, 1'b0, 32'hFFFF_ABFF, 1'b0, 1'b0, 8'd10}, // R10
        '{w_bf(3'd2, 5'd4, 5'd0, 5'd8),  32'h1234_5678, 32'hFFFF_FFFF, 1'b1, 32'h1234_5678, 1'b1, 1'b0, 8'd9},  // R9
        '{w_bf(3'd2, 5'd0, 5'd8, 5'd28), 32'h0AAA_AAAA, 32'h0000_00FF, 1'b0, 32'hFAAA_AAAA, 1'b0, 1'b0, 8'd10}, // R10
        '{w_bf(3'd3, 5'd0, 5'd4, 5'd4),  32'h8,         32'h0000_1200, 1'b1, 32'h20,        1'b1, 1'b0, 8'd11}, // R11
        '{w_bf(3'd3, 5'd0, 5'd4, 5'd4),  32'h28,        32'h0000_1200, 1'b0, 32'h20,        1'b0, 1'b0, 8'd11}, // R11
        '{w_bf(3'd4, 5'd8, 5'd4, 5'd0),  32'd16,        32'h0000_0300, 1'b0, 32'h0003_0000, 1'b0, 1'b0, 8'd12}, // R12
        '{w_bf(3'd4, 5'd0, 5'd31, 5'd0), 32'd0,         32'hFFFF_FFFF, 1'b1, 32'h7FFF_FFFF, 1'b1, 1'b0, 8'd9},  // R9
        '{{29'd0, 3'd5},  32'h55,       32'h66,        1'b1, 32'h0,         1'b1, 1'b0, 8'd3},  // R3
        '{{29'd0, 3'd7},  32'h55,       32'h66,        1'b0, 32'h0,         1'b0, 1'b0, 8'd3}   // R3
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [31:0] w, input logic [31:0] a,
                         input logic [31:0] b, input logic ci);
        @(negedge clk);
        in_valid = v; instr = w; src_a = a; src_b = b; carry_in = ci;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; instr = '0; src_a = '0; src_b = '0; carry_in = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 result", result, 32'd0);
        check("R1 carry/bad", {30'd0, carry_out, bad_op}, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VECS[i].w, VECS[i].a, VECS[i].b, VECS[i].ci);
            @(negedge clk);
            check($sformatf("R%0d vec %0d result", VECS[i].req, i), result, VECS[i].er);
            check($sformatf("R%0d vec %0d carry", VECS[i].req, i), {31'd0, carry_out}, {31'd0, VECS[i].ec});
            check($sformatf("R%0d vec %0d bad_op", VECS[i].req, i), {31'd0, bad_op}, {31'd0, VECS[i].eb});
            check($sformatf("R2 vec %0d out_valid", i), {31'd0, out_valid}, 32'd1);
            in_valid = 1'b0;
        end

        // R2 hold: load a known value, then idle with different inputs
        drive(1'b1, w_alu(0), 32'hFFFF_FFFF, 32'h1, 1'b0);
        drive(1'b0, w_alu(5), 32'h1234, 32'h5678, 1'b0);
        @(negedge clk);
        check("R2 hold out_valid", {31'd0, out_valid}, 32'd0);
        check("R2 hold result", result, 32'h0);
        check("R2 hold carry", {31'd0, carry_out}, 32'd1);
        check("R2 hold bad_op", {31'd0, bad_op}, 32'd0);

        // R7 then R13: error flag clears on next valid non-ALU instruction
        drive(1'b1, w_alu(20), 32'h9, 32'h9, 1'b1);
        @(negedge clk);
        check("R7 code 20 bad_op", {31'd0, bad_op}, 32'd1);
        drive(1'b1, w_bf(3'd4, 5'd0, 5'd8, 5'd0), 32'd4, 32'hAB, 1'b0);
        @(negedge clk);
        check("R13 bf clears bad_op", {31'd0, bad_op}, 32'd0);
        check("R12 bf result", result, 32'h0000_0AB0);

        // R1 reset in mid-run
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        check("R1 mid-run result", result, 32'd0);
        check("R1 mid-run out_valid", {31'd0, out_valid}, 32'd0);
        rst = 1'b0; in_valid = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule